// File: doc/BRIEF.md
# Packed Halfword Compare Unit

This combinational unit executes three packed compare operations on pairs of 32-bit source values, each of which carries two signed 16-bit lanes. It decodes an instruction word and selects one of three tests: equality, signed less-than, or signed less-than-or-equal. It applies that test to the upper lanes and to the lower lanes independently. The two one-bit outcomes are merged into a copy of the incoming DSP control register, which is handed back with a write enable.

An execute stage places the unit between its operand read and its control-register write port. When DSP access is switched off, a recognised compare raises a DSP-disabled exception and requests no write. A word that belongs to the compare group but carries an unknown minor code raises a reserved-instruction exception. Words from outside the group leave every output quiet and pass the control value through unchanged.

Top module: `phcmp_unit`

## Requirements
- R1: Instruction fields are major opcode insn[31:26] (parameter, default 6'b001000), rt index [25:21], rs index [20:16], don't-care [15:10], minor code [9:3] and tail [2:0]. A word is in the compare group only when the major opcode matches and the tail equals 3'b101.
- R2: Minor code 7'b0000000 selects equality. Each lane result is 1 when the two lanes are bit-for-bit identical.
- R3: Minor code 7'b0001000 selects signed less-than. A lane result is 1 when the rs lane, read as two's complement, is below the rt lane.
- R4: Minor code 7'b0010000 selects signed less-or-equal. A lane result is 1 when the rs lane is below or equal to the rt lane, with both lanes signed.
- R5: On a write, ctl_out[25] holds the result for bits 31..16 and ctl_out[24] holds the result for bits 15..0.
- R6: On a write, every ctl_out bit other than 25..24, including 27..26, equals ctl_in.
- R7: A recognised compare with dsp_en low asserts exc_dsp_off, keeps ctl_we low and passes ctl_in through unchanged.
- R8: A compare-group word with any other minor code asserts exc_resv whatever dsp_en is. It also keeps ctl_we low and passes ctl_in through.
- R9: A word outside the compare group asserts none of ctl_we, exc_dsp_off and exc_resv, and ctl_out equals ctl_in.
- R10: The index fields and the don't-care field have no effect on any output. At most one of ctl_we, exc_dsp_off and exc_resv is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| rs_val | input | 32 | First source value, two signed lanes |
| rt_val | input | 32 | Second source value, two signed lanes |
| dsp_en | input | 1 | DSP resources accessible |
| ctl_in | input | 32 | Current DSP control register |
| ctl_we | output | 1 | Control register write request |
| ctl_out | output | 32 | Updated control register value |
| exc_dsp_off | output | 1 | DSP-disabled exception |
| exc_resv | output | 1 | Reserved-instruction exception |

## Verification
The unit holds no state, so a decode or compare fault shows up at the ports in the same evaluation as the stimulus that triggers it. There is no later cycle in which a fault could stay hidden. A wrong lane select or a wrong signedness shows as a flipped bit 25 or bit 24 only for certain operand pairs, so the bench pairs 0x7FFF, 0x8000, 0xFFFF and 0x0000 in every combination, with the two lanes given different pairs. A wrong write mask shows as a change in bits 27..26 or elsewhere, which the bench catches by driving dense control patterns.

// File: rtl/phcmp_unit.sv
module phcmp_unit #(
  parameter logic [5:0] MAJOR   = 6'b001000,
  parameter int         LANE_W  = 16,
  parameter int         LANES   = 2,
  parameter int         CC_BASE = 24
) (
  input  logic [LANES*LANE_W-1:0] insn,
  input  logic [LANES*LANE_W-1:0] rs_val,
  input  logic [LANES*LANE_W-1:0] rt_val,
  input  logic                    dsp_en,
  input  logic [LANES*LANE_W-1:0] ctl_in,
  output logic                    ctl_we,
  output logic [LANES*LANE_W-1:0] ctl_out,
  output logic                    exc_dsp_off,
  output logic                    exc_resv
);
  localparam int          DW      = LANES * LANE_W;
  localparam logic [2:0]  TAIL    = 3'b101;
  localparam logic [6:0]  MIN_EQ  = 7'b0000000;
  localparam logic [6:0]  MIN_LT  = 7'b0001000;
  localparam logic [6:0]  MIN_LE  = 7'b0010000;

  logic [5:0] major;
  logic [6:0] minor;
  logic [2:0] tail;
  logic       in_group, known;
  logic [LANES-1:0] lane_eq, lane_lt, res;
  logic       unused_fields;

  assign major         = insn[DW-1 -: 6];
  assign minor         = insn[9:3];
  assign tail          = insn[2:0];
  assign unused_fields = ^insn[25:10];

  assign in_group = (major == MAJOR) && (tail == TAIL);
  assign known    = (minor == MIN_EQ) || (minor == MIN_LT) || (minor == MIN_LE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [LANE_W-1:0] a, b;
    assign a          = rs_val[g*LANE_W +: LANE_W];
    assign b          = rt_val[g*LANE_W +: LANE_W];
    assign lane_eq[g] = (a == b);
    assign lane_lt[g] = (a < b);
  end

  always_comb begin
    unique case (minor)
      MIN_LT:  res = lane_lt;
      MIN_LE:  res = lane_lt | lane_eq;
      default: res = lane_eq;
    endcase
  end

  assign ctl_we      = in_group && known && dsp_en;
  assign exc_dsp_off = in_group && known && !dsp_en;
  assign exc_resv    = in_group && !known;

  always_comb begin
    ctl_out = ctl_in;
    if (ctl_we) ctl_out[CC_BASE +: LANES] = res;
  end

  always_comb begin
    // R6
    keep_other_bits_chk: assert ((ctl_out | ({LANES{1'b1}} << CC_BASE)) ==
                                 (ctl_in  | ({LANES{1'b1}} << CC_BASE)))
      else $error("bits outside condition pair changed");
    // R7
    no_write_when_off_chk: assert (!exc_dsp_off || (!ctl_we && ctl_out == ctl_in && !dsp_en))
      else $error("disabled compare disturbed control value");
    // R8
    resv_quiet_chk: assert (!exc_resv || (!ctl_we && ctl_out == ctl_in))
      else $error("reserved word disturbed control value");
    // R10
    one_outcome_chk: assert ($onehot0({ctl_we, exc_dsp_off, exc_resv}))
      else $error("more than one outcome active");
    // R2
    eq_lanes_chk: assert (!(ctl_we && minor == MIN_EQ) ||
                          (ctl_out[CC_BASE+1] == (rs_val[31:16] == rt_val[31:16]) &&
                           ctl_out[CC_BASE]   == (rs_val[15:0]  == rt_val[15:0])))
      else $error("equality result mismatch");
  end
endmodule

// File: tb/sim_phcmp_unit.sv
module sim_phcmp_unit;
  localparam logic [5:0] MAJ = 6'b001000;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] insn, rs_val, rt_val, ctl_in, ctl_out;
  logic dsp_en, ctl_we, exc_dsp_off, exc_resv;
  int n_run = 0, n_fail = 0;

  phcmp_unit #(.MAJOR(MAJ)) u0 (
    .insn(insn), .rs_val(rs_val), .rt_val(rt_val), .dsp_en(dsp_en),
    .ctl_in(ctl_in), .ctl_we(ctl_we), .ctl_out(ctl_out),
    .exc_dsp_off(exc_dsp_off), .exc_resv(exc_resv));

  function automatic logic [31:0] mk(input logic [5:0] maj, input logic [6:0] mn,
                                     input logic [2:0] tl, input logic [15:0] mid);
    return {maj, mid, mn, tl};
  endfunction

  function automatic logic lane_res(input int cond, input logic [15:0] a, input logic [15:0] b);
    case (cond)
      0: return a == b;
      1: return $signed(a) < $signed(b);
      default: return $signed(a) <= $signed(b);
    endcase
  endfunction

  function automatic logic [6:0] minor_of(input int cond);
    case (cond)
      0: return 7'b0000000;
      1: return 7'b0001000;
      default: return 7'b0010000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                       input logic en, input logic [31:0] c);
    @(negedge clk);
    insn = i; rs_val = a; rt_val = b; dsp_en = en; ctl_in = c;
    #2;
  endtask

  task automatic t_idle;
    drive(32'h0, 32'h0, 32'h0, 1'b1, 32'h0F0F_0F0F);
    chk("R9 idle we", {31'b0, ctl_we}, 32'd0);
    chk("R9 idle exc", {30'b0, exc_dsp_off, exc_resv}, 32'd0);
    chk("R9 idle passthru", ctl_out, 32'h0F0F_0F0F);
  endtask

  task automatic t_cmp(input int cond, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic [15:0] mid);
    logic [31:0] exp;
    string tag;
    tag = (cond == 0) ? "R2" : (cond == 1) ? "R3" : "R4";
    drive(mk(MAJ, minor_of(cond), 3'b101, mid), a, b, 1'b1, c);
    exp = c;
    exp[25] = lane_res(cond, a[31:16], b[31:16]);
    exp[24] = lane_res(cond, a[15:0], b[15:0]);
    chk({tag, " R5 R6 value"}, ctl_out, exp);
    chk({tag, " we"}, {31'b0, ctl_we}, 32'd1);
    chk("R10 no exc", {30'b0, exc_dsp_off, exc_resv}, 32'd0);
  endtask

  task automatic t_boundaries;
    logic [15:0] v [4];
    v[0] = 16'h7FFF; v[1] = 16'h8000; v[2] = 16'hFFFF; v[3] = 16'h0000;
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          t_cmp(c, {v[i], v[j]}, {v[j], v[(j+1)%4]},
                (i[0] ? 32'hFFFF_FFFF : 32'h0C00_0000), 16'(i*4+j));
  endtask

  task automatic t_lane_order;
    drive(mk(MAJ, 7'b0001000, 3'b101, 16'h0), 32'h8000_0005, 32'h0000_0003, 1'b1, 32'h0);
    chk("R5 upper=1 lower=0", ctl_out, 32'h0200_0000);
    drive(mk(MAJ, 7'b0000000, 3'b101, 16'h0), 32'h1234_ABCD, 32'h1235_ABCD, 1'b1, 32'hFFFF_FFFF);
    chk("R5 R6 upper=0 lower=1", ctl_out, 32'hFDFF_FFFF);
  endtask

  task automatic t_disabled;
    drive(mk(MAJ, 7'b0010000, 3'b101, 16'h0), 32'h0, 32'h0, 1'b0, 32'h5A5A_5A5A);
    chk("R7 exc", {30'b0, exc_dsp_off, exc_resv}, 32'd2);
    chk("R7 we", {31'b0, ctl_we}, 32'd0);
    chk("R7 passthru", ctl_out, 32'h5A5A_5A5A);
  endtask

  task automatic t_reserved;
    drive(mk(MAJ, 7'b0000001, 3'b101, 16'h0), 32'h0, 32'h0, 1'b1, 32'h1234_5678);
    chk("R8 exc", {30'b0, exc_dsp_off, exc_resv}, 32'd1);
    chk("R8 passthru", ctl_out, 32'h1234_5678);
    drive(mk(MAJ, 7'b0011000, 3'b101, 16'h0), 32'h0, 32'h0, 1'b0, 32'h1234_5678);
    chk("R8 exc while off", {30'b0, exc_dsp_off, exc_resv}, 32'd1);
    chk("R8 we", {31'b0, ctl_we}, 32'd0);
  endtask

  task automatic t_foreign;
    drive(mk(6'b001001, 7'b0000000, 3'b101, 16'h0), 32'h0, 32'h0, 1'b1, 32'hCAFE_F00D);
    chk("R1 R9 major mismatch", {29'b0, ctl_we, exc_dsp_off, exc_resv}, 32'd0);
    chk("R9 passthru", ctl_out, 32'hCAFE_F00D);
    drive(mk(MAJ, 7'b0000000, 3'b100, 16'h0), 32'h0, 32'h0, 1'b1, 32'hCAFE_F00D);
    chk("R1 R9 tail mismatch", {29'b0, ctl_we, exc_dsp_off, exc_resv}, 32'd0);
    chk("R9 passthru tail", ctl_out, 32'hCAFE_F00D);
  endtask

  task automatic t_dont_care;
    drive(mk(MAJ, 7'b0010000, 3'b101, 16'hFFFF), 32'hFFFF_0001, 32'hFFFF_0000, 1'b1, 32'h0);
    chk("R10 ignored fields", ctl_out, 32'h0200_0000);
    chk("R10 ignored fields we", {29'b0, ctl_we, exc_dsp_off, exc_resv}, 32'd4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    insn = 0; rs_val = 0; rt_val = 0; dsp_en = 0; ctl_in = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_lane_order();
    t_boundaries();
    t_disabled();
    t_reserved();
    t_foreign();
    t_dont_care();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule